// File: doc/BRIEF.md
# Rate One-Third Convolutional Encoder

This block is a serial forward error correction encoder. Each cycle on which a message bit is offered with its valid strobe, the bit is combined with the four bits held in a shift register. Three modulo-two adder trees produce three coded bits from that combination. The shift register then advances by one place, so the code has a constraint length of five. The three adders use the fixed generators 25, 33 and 37 (octal). The coded triple is registered and appears together with an output valid strobe one clock after the input was accepted.

A flush request drives four zero bits through the encoder. These produce twelve tail bits and leave the register in the all-zero state, so a decoder can terminate its trellis. While the tail is being produced, the block raises a flush-active flag and ignores new input bits and new flush requests. A bit offered on the same cycle as a flush request is encoded first. The tail follows it on the next four cycles.

Top module: `conv3_encoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the four memory stages, `out_vld`, `out_sym` and `flush_active` to zero.
- R2: `out_sym[0]` is the XOR of the current input bit, m2 and m4 (generator 25 octal). Generator bit 4 taps the current bit, bits 3 down to 0 tap m1 down to m4.
- R3: `out_sym[1]` is the XOR of the current input bit, m1, m3 and m4 (generator 33 octal).
- R4: `out_sym[2]` is the XOR of the current input bit and all four memory stages m1 to m4 (generator 37 octal).
- R5: On each encoding step the memory shifts by one place: m4 takes m3, m3 takes m2, m2 takes m1 and m1 takes the current bit. A single 1 followed by zeros therefore produces the triples 111, 110, 101, 110, 111, written as `out_sym[2:0]`.
- R6: The triple computed from a bit accepted at clock edge N is on `out_sym`, with `out_vld` high, during the cycle that follows edge N.
- R7: On a cycle with `in_vld` low and no tail step, the memory holds its contents. In the following cycle `out_vld` is low and `out_sym` keeps its last value.
- R8: A flush request seen at edge N, while no flush is active, causes four tail steps with a zero input bit at edges N+1 to N+4. `flush_active` is high in the four cycles after edge N. Each tail step gives an output triple with `out_vld` high, and after the fourth step all memory stages are zero.
- R9: When `in_vld` and `flush_req` are both high on the same cycle, the offered bit is encoded at that edge and the four tail steps follow it.
- R10: While `flush_active` is high, `in_vld`, `in_bit` and `flush_req` have no effect on the output triples or on the length of the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Message bit |
| in_vld | input | 1 | Marks `in_bit` as valid this cycle |
| flush_req | input | 1 | Request to append a four-bit zero tail |
| out_sym | output | 3 | Coded triple: bit 0 from generator 25, bit 1 from 33, bit 2 from 37 |
| out_vld | output | 1 | Marks `out_sym` as a new triple |
| flush_active | output | 1 | High while tail bits are being produced |

## Verification
Two events can fall on the same clock edge: a message bit being accepted and a flush being requested. A further collision arises when fresh bits and flush requests keep arriving while a tail is being produced. The bench provokes the first case directly, with both strobes high together, and provokes the second by holding `in_vld` and `flush_req` high through a whole tail. The random stream adds rare flush requests on top of gapped and back-to-back valid patterns, so both cases also come up by chance. The bench's own cycle model decides which bit goes in at each edge. Each triple is then checked against taps written out bit by bit, and the tail length and final zero state are checked through the response to the next message bit.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  // Default code shape: constraint length, output count and generators.
  localparam int unsigned DEF_K    = 5;
  localparam int unsigned DEF_NOUT = 3;
  // Packed generators, output 0 in the low field. Within a field the MSB
  // taps the current bit, and the following bits tap m1 .. m(K-1).
  localparam logic [DEF_NOUT*DEF_K-1:0] DEF_GENS = {5'o37, 5'o33, 5'o25};

  // Modulo-two sum of the window bits selected by a generator.
  function automatic logic masked_parity(input logic [31:0] gen,
                                         input logic [31:0] win);
    return ^(gen & win);
  endfunction
endpackage

// File: rtl/conv3_state_reg.sv
module conv3_state_reg #(
  parameter int unsigned MEM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           din,
  output logic [MEM-1:0] mem   // mem[MEM-1] is m1, mem[0] is the oldest stage
);
  always_ff @(posedge clk) begin
    if (rst)       mem <= '0;
    else if (step) mem <= {din, mem[MEM-1:1]};
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(mem));
  // R5
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (mem[MEM-2:0] == $past(mem[MEM-1:1])) && (mem[MEM-1] == $past(din)));
endmodule

// File: rtl/conv3_tail_ctrl.sv
module conv3_tail_ctrl #(
  parameter int unsigned MEM = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic flush_req,
  output logic accept,
  output logic tail_step,
  output logic flush_active
);
  localparam int unsigned CW = $clog2(MEM + 1);
  localparam logic [CW-1:0] TAIL_LEN = CW'(MEM);

  logic [CW-1:0] left_q;
  logic          start_tail;

  assign flush_active = (left_q != '0);
  assign tail_step    = flush_active;
  assign accept       = in_vld && !flush_active;
  assign start_tail   = flush_req && !flush_active;

  always_ff @(posedge clk) begin
    if (rst)             left_q <= '0;
    else if (start_tail) left_q <= TAIL_LEN;
    else if (tail_step)  left_q <= left_q - 1'b1;
  end

  // R8
  tail_start_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_active) |=> flush_active);
  // R10
  tail_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    flush_active |=> (left_q == $past(left_q) - 1'b1));
  // R10
  no_accept_in_tail_chk: assert property (@(posedge clk) disable iff (rst)
    !(accept && tail_step));
endmodule

// File: rtl/conv3_tap_net.sv
module conv3_tap_net
  import conv3_pkg::*;
#(
  parameter int unsigned K    = DEF_K,
  parameter int unsigned NOUT = DEF_NOUT,
  parameter logic [NOUT*K-1:0] GENS = DEF_GENS
) (
  input  logic [K-1:0]    win,   // win[K-1] current bit, then m1 .. m(K-1)
  output logic [NOUT-1:0] sym
);
  for (genvar g = 0; g < NOUT; g++) begin : g_tree
    localparam logic [K-1:0] GEN = GENS[g*K +: K];
    assign sym[g] = masked_parity(32'(GEN), 32'(win));
  end
endmodule

// File: rtl/conv3_encoder.sv
module conv3_encoder
  import conv3_pkg::*;
#(
  parameter int unsigned K    = DEF_K,
  parameter int unsigned NOUT = DEF_NOUT,
  parameter logic [NOUT*K-1:0] GENS = DEF_GENS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_bit,
  input  logic            in_vld,
  input  logic            flush_req,
  output logic [NOUT-1:0] out_sym,
  output logic            out_vld,
  output logic            flush_active
);
  localparam int unsigned MEM = K - 1;

  logic            accept;
  logic            tail_step;
  logic            step;
  logic            din;
  logic [MEM-1:0]  mem;
  logic [K-1:0]    win;
  logic [NOUT-1:0] sym_next;

  conv3_tail_ctrl #(.MEM(MEM)) u_tail (
    .clk(clk), .rst(rst), .in_vld(in_vld), .flush_req(flush_req),
    .accept(accept), .tail_step(tail_step), .flush_active(flush_active)
  );

  assign step = accept || tail_step;
  assign din  = tail_step ? 1'b0 : in_bit;
  assign win  = {din, mem};

  conv3_state_reg #(.MEM(MEM)) u_state (
    .clk(clk), .rst(rst), .step(step), .din(din), .mem(mem)
  );

  conv3_tap_net #(.K(K), .NOUT(NOUT), .GENS(GENS)) u_taps (
    .win(win), .sym(sym_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sym <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= step;
      if (step) out_sym <= sym_next;
    end
  end

  // R6
  data_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !flush_active) |=> out_vld);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !flush_active) |=> (!out_vld && $stable(out_sym)));
  // R8
  tail_emits_chk: assert property (@(posedge clk) disable iff (rst)
    flush_active |=> out_vld);
  // R8
  tail_ends_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_active) |-> (mem == '0));
  // R10
  tail_zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    flush_active |=> !mem[MEM-1]);
endmodule

// File: tb/test_conv3_encoder.sv
module test_conv3_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_bit = 1'b0;
  logic       in_vld = 1'b0;
  logic       flush_req = 1'b0;
  logic [2:0] out_sym;
  logic       out_vld;
  logic       flush_active;

  int total = 0;
  int bad   = 0;

  // bench model state
  logic m1 = 0, m2 = 0, m3 = 0, m4 = 0;
  int   tails = 0;
  logic [2:0] held = 3'b000;

  always #2 clk = ~clk;   // 250 MHz

  conv3_encoder i_conv3_encoder (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_vld(in_vld),
    .flush_req(flush_req), .out_sym(out_sym), .out_vld(out_vld),
    .flush_active(flush_active)
  );

  function automatic logic [2:0] ref_triple(input logic c, input logic a1,
      input logic a2, input logic a3, input logic a4);
    logic x1, x2, x3;
    x1 = c ^ a2 ^ a4;                 // generator 25
    x2 = c ^ a1 ^ a3 ^ a4;            // generator 33
    x3 = c ^ a1 ^ a2 ^ a3 ^ a4;       // generator 37
    return {x3, x2, x1};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock of stimulus, followed by checks against the bench model.
  task automatic cyc(input logic v, input logic b, input logic f, input string ctx);
    logic step, d, ev;
    logic [2:0] es;
    @(negedge clk);
    in_vld = v; in_bit = b; flush_req = f;
    if (tails > 0) begin
      step = 1; d = 0; tails--;           // R10: inputs ignored in tail
    end else begin
      step = v; d = b;
      if (f) tails = 4;
    end
    ev = step;
    es = step ? ref_triple(d, m1, m2, m3, m4) : held;
    @(posedge clk); #1;
    check(out_vld == ev, "R6", {ctx, " out_vld"}, out_vld, ev);
    check(out_sym[0] == es[0], "R2", {ctx, " x1"}, out_sym[0], es[0]);
    check(out_sym[1] == es[1], "R3", {ctx, " x2"}, out_sym[1], es[1]);
    check(out_sym[2] == es[2], "R4", {ctx, " x3"}, out_sym[2], es[2]);
    check(flush_active == (tails > 0), "R8", {ctx, " flush_active"},
          flush_active, (tails > 0));
    if (step) begin
      m4 = m3; m3 = m2; m2 = m1; m1 = d; held = es;
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(out_vld == 0, "R1", "reset out_vld", out_vld, 0);
    check(out_sym == 0, "R1", "reset out_sym", out_sym, 0);
    check(flush_active == 0, "R1", "reset flush_active", flush_active, 0);
    @(negedge clk); rst = 0;

    // R5: impulse response after reset shows shift order and a zero start
    cyc(1, 1, 0, "R5 impulse");
    check(out_sym == 3'b111, "R5", "impulse t0", out_sym, 3'b111);
    cyc(1, 0, 0, "R5 impulse");
    check(out_sym == 3'b110, "R5", "impulse t1", out_sym, 3'b110);
    cyc(1, 0, 0, "R5 impulse");
    check(out_sym == 3'b101, "R5", "impulse t2", out_sym, 3'b101);
    cyc(1, 0, 0, "R5 impulse");
    check(out_sym == 3'b110, "R5", "impulse t3", out_sym, 3'b110);
    cyc(1, 0, 0, "R5 impulse");
    check(out_sym == 3'b111, "R5", "impulse t4", out_sym, 3'b111);

    // R7: gap holds memory and output
    cyc(1, 1, 0, "R7 pre");
    cyc(1, 1, 0, "R7 pre");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R7 gap");
    check(out_vld == 0, "R7", "gap out_vld", out_vld, 0);
    cyc(1, 0, 0, "R7 post");

    // R8: plain flush, then a 1 must see an all-zero memory
    cyc(0, 0, 1, "R8 flush");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, "R8 tail");
    check(flush_active == 0, "R8", "tail end", flush_active, 0);
    cyc(1, 1, 0, "R8 after");
    check(out_sym == 3'b111, "R8", "zero state after tail", out_sym, 3'b111);

    // R9: bit and flush in the same cycle
    cyc(1, 1, 0, "R9 pre");
    cyc(1, 1, 1, "R9 both");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, "R9 tail");
    cyc(1, 1, 0, "R9 after");
    check(out_sym == 3'b111, "R9", "zero state after tail", out_sym, 3'b111);

    // R10: bits and flush requests pushed during a tail are ignored
    cyc(0, 0, 1, "R10 flush");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, "R10 busy");
    check(flush_active == 0, "R10", "tail length", flush_active, 0);
    cyc(1, 1, 0, "R10 after");
    check(out_sym == 3'b111, "R10", "ignored bits", out_sym, 3'b111);

    // random stream: gapped and back-to-back valid, rare flushes
    for (int i = 0; i < 4000; i++) begin
      logic v, b, f;
      v = ($urandom_range(9) < 7);
      b = $urandom_range(1);
      f = ($urandom_range(39) == 0);
      cyc(v, b, f, "random");
    end
    for (int i = 0; i < 300; i++) cyc(1, $urandom_range(1), 0, "random burst");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule